// File: doc/BRIEF.md
# Prioritized Event Interrupt Controller

This block decides, once per clock, which interrupt a processor core should take next. It watches seventeen maskable event request lines and six non-maskable exception request lines. It reports a single winner to the core as a registered tuple: a request flag, an exception flag, the winner's index, the winner's effective priority level and the winner's vector address.

Event sources are qualified by four conditions: a global enable, a per-source enable, a 3-bit priority setting, and a comparison against the core's current execution level. A setting of zero turns a source off. Any nonzero setting v is raised into the upper half of a 4-bit level space as 8+v. Among qualified sources, the highest level wins, and a tie goes to the lowest index. Exceptions bypass all of this. When any exception is pending, the block picks the highest-precedence pending exception, whatever the event state is.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every output to zero on the next clock edge and holds the outputs there while it is asserted.
- R2: While `glb_en` is 0, no event source is reported; with no exception pending, `take_req` is 0 one cycle later.
- R3: Event source i is a candidate only when bit i of `evt_pend` and bit i of `evt_en` are both 1.
- R4: A priority setting of 0 (bits `evt_prio[3*i+2:3*i]`) removes source i from arbitration.
- R5: A nonzero setting v gives source i the effective level 8+v, which is reported on `take_lvl`.
- R6: An event source is a candidate only if its effective level is strictly greater than `core_lvl`.
- R7: Among candidates, the one with the highest effective level wins.
- R8: Among candidates that share the winning level, the lowest index wins.
- R9: Any pending exception beats every event source. Among exceptions, bit 0 of `exc_pend` has the highest precedence and bit 5 the lowest. The bits are, in order: reset, breakpoint, trace, stack overflow, divide by zero, user return-from-interrupt. The winning exception sets `take_exc`=1, `take_idx` to its bit number and `take_lvl` to 15.
- R10: The vector of exception bit r is 4*r, which gives 0x0000 to 0x0014. The vector of event source i is 0x0080 + 4*i.
- R11: Outputs are registered. Each output reflects the inputs sampled at the previous rising edge and does not change between edges.
- R12: When nothing wins, `take_req`, `take_exc`, `take_idx`, `take_lvl` and `take_vec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable for all event sources |
| evt_pend | input | 17 | Event request lines, bit i = source i |
| evt_en | input | 17 | Per-source enables |
| evt_prio | input | 51 | Priority settings, 3 bits per source, source i at [3i+2:3i] |
| core_lvl | input | 4 | Core's current execution level |
| exc_pend | input | 6 | Exception request lines, bit 0 highest precedence |
| take_req | output | 1 | A winner is being reported |
| take_exc | output | 1 | The winner is an exception |
| take_idx | output | 5 | Source index or exception bit number |
| take_lvl | output | 4 | Effective level of the winner (15 for exceptions) |
| take_vec | output | 16 | Vector address of the winner |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. The bench changes the inputs on the falling edge and computes the expected tuple from those inputs at once. It then compares all five outputs at the next falling edge, which comes after the one capturing edge. For R11, the bench also samples just after it changes the inputs, before that edge, and confirms that the outputs still hold the previous result.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Exception bits in precedence order, highest first.
  typedef enum int unsigned {
    EXC_RST   = 0,
    EXC_BRK   = 1,
    EXC_TRC   = 2,
    EXC_STK   = 3,
    EXC_DIV0  = 4,
    EXC_URETI = 5
  } exc_kind_e;

  // Effective level of a priority setting: 0 stays 0, v maps to 2^pw + v.
  function automatic int unsigned eff_level(input int unsigned setting,
                                            input int unsigned pw);
    if (setting == 0) return 0;
    return (1 << pw) + setting;
  endfunction

  // Vector of event source idx.
  function automatic int unsigned evt_vector(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned idx);
    return base + step * idx;
  endfunction

  // Vector of exception with precedence rank r.
  function automatic int unsigned exc_vector(input int unsigned step,
                                             input int unsigned rank);
    return step * rank;
  endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT = 17,
  parameter int PRIO_W  = 3,
  localparam int LVL_W  = PRIO_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      glb_en,
  input  logic [NUM_EVT-1:0]        pend,
  input  logic [NUM_EVT-1:0]        en,
  input  logic [NUM_EVT*PRIO_W-1:0] prio,
  input  logic [LVL_W-1:0]          core_lvl,
  output logic [NUM_EVT-1:0]        elig,
  output logic [NUM_EVT*LVL_W-1:0]  lvl
);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_src
    logic [PRIO_W-1:0] setting;
    logic [LVL_W-1:0]  level;
    logic              above_core;

    assign setting    = prio[i*PRIO_W +: PRIO_W];
    assign level      = LVL_W'(eff_level(int'(setting), PRIO_W));
    assign above_core = level > core_lvl;
    assign elig[i]    = glb_en & pend[i] & en[i] & above_core;
    assign lvl[i*LVL_W +: LVL_W] = level;

    AST_ZERO_SETTING_IDLE: assert property (@(posedge clk) disable iff (rst)
      (setting == '0) |-> !elig[i]);  // R4
    AST_ELIG_ABOVE_CORE: assert property (@(posedge clk) disable iff (rst)
      elig[i] |-> (lvl[i*LVL_W +: LVL_W] > core_lvl));  // R6
    AST_NONZERO_UPPER: assert property (@(posedge clk) disable iff (rst)
      (setting != '0) |-> lvl[i*LVL_W + LVL_W - 1]);  // R5
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_EVT = 17,
  parameter int LVL_W   = 4,
  parameter int IDX_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_EVT-1:0]       elig,
  input  logic [NUM_EVT*LVL_W-1:0] lvl,
  output logic                     win_any,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);

  // Scan upward; a later source replaces the best only on a strictly higher
  // level, so the lowest index keeps a tie.
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (elig[i] && (!win_any || lvl[i*LVL_W +: LVL_W] > win_lvl)) begin
        win_any = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i*LVL_W +: LVL_W];
      end
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    AST_NONE_HIGHER: assert property (@(posedge clk) disable iff (rst)
      elig[i] |-> (win_any && lvl[i*LVL_W +: LVL_W] <= win_lvl));  // R7
    AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (rst)
      (elig[i] && lvl[i*LVL_W +: LVL_W] == win_lvl) |-> (win_idx <= IDX_W'(i)));  // R8
  end

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    win_any |-> elig[win_idx]);  // R3

endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int NUM_EXC = 6,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] pend,
  output logic               exc_any,
  output logic [IDX_W-1:0]   exc_rank
);

  // Downward scan: the last assignment is the lowest pending bit.
  always_comb begin
    exc_any  = 1'b0;
    exc_rank = '0;
    for (int r = NUM_EXC - 1; r >= 0; r--) begin
      if (pend[r]) begin
        exc_any  = 1'b1;
        exc_rank = IDX_W'(r);
      end
    end
  end

  AST_RANK_PENDING: assert property (@(posedge clk) disable iff (rst)
    exc_any |-> pend[exc_rank]);  // R9
  AST_RESET_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    pend[0] |-> (exc_rank == '0));  // R9
  AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |-> exc_any);  // R9

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT  = 17,
  parameter int NUM_EXC  = 6,
  parameter int PRIO_W   = 3,
  parameter int VEC_W    = 16,
  parameter int EVT_BASE = 'h80,
  parameter int VEC_STEP = 4,
  localparam int LVL_W   = PRIO_W + 1,
  localparam int IDX_W   = $clog2((NUM_EVT > NUM_EXC) ? NUM_EVT : NUM_EXC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      glb_en,
  input  logic [NUM_EVT-1:0]        evt_pend,
  input  logic [NUM_EVT-1:0]        evt_en,
  input  logic [NUM_EVT*PRIO_W-1:0] evt_prio,
  input  logic [LVL_W-1:0]          core_lvl,
  input  logic [NUM_EXC-1:0]        exc_pend,
  output logic                      take_req,
  output logic                      take_exc,
  output logic [IDX_W-1:0]          take_idx,
  output logic [LVL_W-1:0]          take_lvl,
  output logic [VEC_W-1:0]          take_vec
);

  // Named internal events
  logic [NUM_EVT-1:0]       evt_elig;
  logic [NUM_EVT*LVL_W-1:0] evt_lvl;
  logic                     evt_win;
  logic [IDX_W-1:0]         evt_win_idx;
  logic [LVL_W-1:0]         evt_win_lvl;
  logic                     exc_win;
  logic [IDX_W-1:0]         exc_win_rank;

  logic                     nxt_req;
  logic                     nxt_exc;
  logic [IDX_W-1:0]         nxt_idx;
  logic [LVL_W-1:0]         nxt_lvl;
  logic [VEC_W-1:0]         nxt_vec;

  irq_qualify #(.NUM_EVT(NUM_EVT), .PRIO_W(PRIO_W)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .glb_en   (glb_en),
    .pend     (evt_pend),
    .en       (evt_en),
    .prio     (evt_prio),
    .core_lvl (core_lvl),
    .elig     (evt_elig),
    .lvl      (evt_lvl)
  );

  irq_pick #(.NUM_EVT(NUM_EVT), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .elig    (evt_elig),
    .lvl     (evt_lvl),
    .win_any (evt_win),
    .win_idx (evt_win_idx),
    .win_lvl (evt_win_lvl)
  );

  exc_pick #(.NUM_EXC(NUM_EXC), .IDX_W(IDX_W)) u_exc (
    .clk      (clk),
    .rst      (rst),
    .pend     (exc_pend),
    .exc_any  (exc_win),
    .exc_rank (exc_win_rank)
  );

  always_comb begin
    nxt_req = 1'b0;
    nxt_exc = 1'b0;
    nxt_idx = '0;
    nxt_lvl = '0;
    nxt_vec = '0;
    if (exc_win) begin
      nxt_req = 1'b1;
      nxt_exc = 1'b1;
      nxt_idx = exc_win_rank;
      nxt_lvl = '1;
      nxt_vec = VEC_W'(exc_vector(VEC_STEP, int'(exc_win_rank)));
    end else if (evt_win) begin
      nxt_req = 1'b1;
      nxt_idx = evt_win_idx;
      nxt_lvl = evt_win_lvl;
      nxt_vec = VEC_W'(evt_vector(EVT_BASE, VEC_STEP, int'(evt_win_idx)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_req <= 1'b0;
      take_exc <= 1'b0;
      take_idx <= '0;
      take_lvl <= '0;
      take_vec <= '0;
    end else begin
      take_req <= nxt_req;
      take_exc <= nxt_exc;
      take_idx <= nxt_idx;
      take_lvl <= nxt_lvl;
      take_vec <= nxt_vec;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!take_req && !take_exc && take_vec == '0 && take_lvl == '0));  // R1
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && exc_pend == '0) |=> !take_req);  // R2
  AST_EXC_FIRST: assert property (@(posedge clk) disable iff (rst)
    (exc_pend != '0) |=> (take_req && take_exc));  // R9
  AST_ABOVE_CORE: assert property (@(posedge clk) disable iff (rst)
    (exc_pend == '0) |=> (!take_req || take_lvl > $past(core_lvl)));  // R6
  AST_EXC_VEC_LOW: assert property (@(posedge clk) disable iff (rst)
    take_exc |-> (take_lvl == '1 && take_vec < VEC_W'(EVT_BASE)));  // R10
  AST_EVT_VEC_HIGH: assert property (@(posedge clk) disable iff (rst)
    (take_req && !take_exc) |-> (take_vec >= VEC_W'(EVT_BASE)));  // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !take_req |-> (!take_exc && take_idx == '0 && take_lvl == '0 && take_vec == '0));  // R12

endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        glb_en;
  logic [16:0] evt_pend;
  logic [16:0] evt_en;
  logic [50:0] evt_prio;
  logic [3:0]  core_lvl;
  logic [5:0]  exc_pend;
  logic        take_req;
  logic        take_exc;
  logic [4:0]  take_idx;
  logic [3:0]  take_lvl;
  logic [15:0] take_vec;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Expected tuple
  int e_req, e_exc, e_idx, e_lvl, e_vec;

  always #2 clk = ~clk;  // 250 MHz

  evt_irq_ctrl uut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .evt_pend(evt_pend),
    .evt_en(evt_en), .evt_prio(evt_prio), .core_lvl(core_lvl),
    .exc_pend(exc_pend), .take_req(take_req), .take_exc(take_exc),
    .take_idx(take_idx), .take_lvl(take_lvl), .take_vec(take_vec)
  );

  function automatic int setting_of(int i);
    return int'(evt_prio[i*3 +: 3]);
  endfunction

  // Reference model: exceptions in bit order, then levels from 15 down,
  // each level scanned from index 0 up.
  task automatic model();
    e_req = 0; e_exc = 0; e_idx = 0; e_lvl = 0; e_vec = 0;
    if (rst) return;
    for (int r = 0; r < 6; r++) begin
      if (exc_pend[r]) begin
        e_req = 1; e_exc = 1; e_idx = r; e_lvl = 15; e_vec = 4 * r;
        return;
      end
    end
    if (!glb_en) return;
    for (int l = 15; l > int'(core_lvl); l--) begin
      for (int i = 0; i < 17; i++) begin
        if (evt_pend[i] && evt_en[i] && setting_of(i) != 0 &&
            8 + setting_of(i) == l) begin
          e_req = 1; e_idx = i; e_lvl = l; e_vec = 128 + 4 * i;
          return;
        end
      end
    end
  endtask

  task automatic compare(string tag);
    n_vec++;
    if (int'(take_req) != e_req || int'(take_exc) != e_exc ||
        int'(take_idx) != e_idx || int'(take_lvl) != e_lvl ||
        int'(take_vec) != e_vec) begin
      n_fail++;
      $display("FAIL %s: got req=%0d exc=%0d idx=%0d lvl=%0d vec=%h, expected req=%0d exc=%0d idx=%0d lvl=%0d vec=%h",
               tag, take_req, take_exc, take_idx, take_lvl, take_vec,
               e_req, e_exc, e_idx, e_lvl, e_vec[15:0]);
    end
  endtask

  // Inputs are already set; wait one capturing edge and compare.
  task automatic step(string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear_inputs();
    glb_en = 1'b1; evt_pend = '0; evt_en = '1; evt_prio = '0;
    core_lvl = 4'd0; exc_pend = '0;
  endtask

  task automatic set_prio(int i, int v);
    evt_prio[i*3 +: 3] = 3'(v);
  endtask

  initial begin
    rst = 1'b1;
    clear_inputs();
    set_prio(2, 5); evt_pend[2] = 1'b1;
    step("R1 reset");
    step("R1 reset held");
    rst = 1'b0;
    clear_inputs();
    step("R12 idle");

    set_prio(4, 3); evt_pend[4] = 1'b1;
    step("R5 level 11");
    set_prio(4, 7);
    step("R5 level 15");
    set_prio(4, 1);
    step("R5 level 9");

    glb_en = 1'b0;
    step("R2 global off");
    glb_en = 1'b1;
    evt_en[4] = 1'b0;
    step("R3 source disabled");
    evt_en[4] = 1'b1; evt_pend[4] = 1'b0;
    step("R3 not pending");

    evt_pend[4] = 1'b1; set_prio(4, 0);
    step("R4 setting zero");

    set_prio(4, 1); core_lvl = 4'd9;
    step("R6 equal to core");
    core_lvl = 4'd8;
    step("R6 above core");

    clear_inputs();
    set_prio(1, 2); set_prio(9, 6); set_prio(14, 4);
    evt_pend[1] = 1'b1; evt_pend[9] = 1'b1; evt_pend[14] = 1'b1;
    step("R7 highest level");

    clear_inputs();
    set_prio(3, 5); set_prio(11, 5);
    evt_pend[3] = 1'b1; evt_pend[11] = 1'b1;
    step("R8 tie lowest index");
    evt_pend[3] = 1'b0;
    step("R8 tie other");

    clear_inputs();
    set_prio(16, 2); evt_pend[16] = 1'b1;
    step("R10 last source vector");

    set_prio(0, 7); evt_pend[0] = 1'b1;
    exc_pend = 6'b110100;
    step("R9 exception over events");
    exc_pend = 6'b010000;
    step("R10 divide by zero vector");
    exc_pend = 6'b111111;
    step("R9 reset top");
    glb_en = 1'b0; exc_pend = 6'b100000;
    step("R9 exception ignores global");
    exc_pend = 6'b0; glb_en = 1'b1;

    // R11: right after a change, outputs still hold the earlier result
    clear_inputs();
    set_prio(6, 4); evt_pend[6] = 1'b1;
    step("R11 settle");
    set_prio(6, 6);
    #1;
    compare("R11 no change before edge");
    step("R11 after edge");

    // Random patterns
    for (int k = 0; k < 2000; k++) begin
      glb_en   = ($urandom % 8) != 0;
      evt_pend = 17'($urandom);
      evt_en   = 17'($urandom | $urandom);
      evt_prio = {19'($urandom), 32'($urandom)};
      core_lvl = 4'($urandom);
      exc_pend = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
      rst      = (($urandom % 50) == 0);
      step("R7 R8 R9 random");
    end
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule